// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire clause-22 management bus. Software programs a 16-bit write value into a data register, then writes a command word. The command word carries a read-start bit or a write-start bit, a 5-bit PHY address and a 5-bit register number. The controller then produces the management clock and shifts a complete 64-bit frame on the data line. It tri-states its driver while the PHY answers a read, and clears the start bit once the frame ends.

Completion is detected by polling. Software reads the command word until both start bits read zero. After a read, the low half of the same word holds the value the PHY returned. While a transaction is in flight, further command writes are dropped. Writes to the data register are always accepted, but they take effect only for the next write frame.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: A write with `reg_wr_sel`=0 and `reg_wr_data[26]`=1 starts a read. From the cycle after that write until the frame ends, `cmd_rdata[26]` reads 1. `cmd_rdata[25:21]` shows the PHY address and `cmd_rdata[20:16]` shows the register number. Bits 31:28 always read 0.
- R2: A write with `reg_wr_sel`=0, bit 27 set and bit 26 clear starts a write frame. `cmd_rdata[27]` reads 1 until the frame ends. The 16 data bits are the value last written with `reg_wr_sel`=1 (bits 15:0), captured when the command is accepted.
- R3: The frame is sent in this order: 32 ones, then 0 and 1. Next comes the opcode: 1,0 for a read or 0,1 for a write. The address and register number follow, each MSB first. A write then sends turnaround 1,0 and 16 data bits, MSB first.
- R4: `mdc` is `clk` divided by the even parameter `MDC_DIV`, with a 50 % duty cycle. It is low out of reset and runs continuously.
- R5: `mdio_o` changes only in the cycle in which `mdc` falls. The frame's first bit appears at the first falling edge after the command is accepted. `mdio_i` is sampled in the cycle in which `mdc` rises.
- R6: `mdio_oe` is 1 for frame positions 0 to 63 of a write and positions 0 to 45 of a read. It is 0 during a read's turnaround and data bits (positions 46 to 63), and 0 while idle.
- R7: A frame ends at the falling `mdc` edge after position 63. In that cycle, the start bit clears and `mdio_oe` drops. After a read, `cmd_rdata[15:0]` then holds the 16 bits sampled at positions 48 to 63, with the first sample as the MSB.
- R8: A command write that arrives during a transaction is ignored, as is one with neither start bit set. The command word does not change and the frame in flight does not change. A data-register write during a transaction does not alter the frame in flight.
- R9: After reset, `cmd_rdata` is 0, `mdio_oe` is 0, `mdio_o` is 1 and `mdc` is 0.
- R10: A command with both start bits set runs as a read, and only bit 26 reads back set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the command word, 1 selects the write-data register |
| reg_wr_data | input | 32 | Register write value |
| cmd_rdata | output | 32 | Current command word: start bits, address, register, read result |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Driver enable for `mdio_o` |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
Each result is due a fixed number of cycles after its stimulus. The start bit and the address and register fields appear one cycle after the command write. Each frame bit appears on `mdio_o` in the same cycle in which the falling-edge strobe registers it, so it is visible one cycle after that strobe's clock edge. The read result and the cleared start bit appear one cycle after the 65th falling strobe. The bench reference model advances on every rising clock edge with the same one-register delay. It is compared against `mdc`, `mdio_oe`, `mdio_o` (while driven) and `cmd_rdata` at every falling clock edge, so any result that comes one cycle early or late is reported. The bench also acts as the PHY. It drives `mdio_i` from the model's frame position half a cycle before each rising-strobe edge, so read data is stable whenever it is sampled.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_AW      = 5;
    localparam int REG_AW      = 5;
    localparam int DATA_W      = 16;
    localparam int PRE_BITS    = 32;
    localparam int FRAME_BITS  = PRE_BITS + 4 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int TA_POS      = PRE_BITS + 4 + PHY_AW + REG_AW;
    localparam int RDATA_POS   = TA_POS + 2;
    localparam int CMD_W       = 32;
    localparam int WR_GO_BIT   = 27;
    localparam int RD_GO_BIT   = 26;
    localparam int PHY_LSB     = 21;
    localparam int REG_LSB     = 16;

    typedef struct packed {
        logic                wr_go;
        logic                rd_go;
        logic [PHY_AW-1:0]   phy;
        logic [REG_AW-1:0]   regn;
        logic [DATA_W-1:0]   rdata;
    } cmd_word_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int MDC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = MDC_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;
    logic wrap;

    always_comb begin
        div_d = div_q;
        wrap  = (div_q.cnt == CW'(HALF - 1));
        if (wrap) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc      = div_q.mdc;
    assign rise_stb = wrap & ~div_q.mdc;
    assign fall_stb = wrap &  div_q.mdc;

    // R4
    mdc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.mdc != $past(div_q.mdc)) |-> $past(wrap));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              launch,
    input  logic              launch_rd,
    input  logic [PHY_AW-1:0] launch_phy,
    input  logic [REG_AW-1:0] launch_reg,
    input  logic [DATA_W-1:0] launch_wdata,
    input  logic              mdio_i,
    output logic              mdo,
    output logic              mdo_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic                  busy;
        logic                  started;
        logic                  is_rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] frame;
        logic [DATA_W-1:0]     shreg;
        logic                  mdo;
        logic                  oe;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [IDX_W-1:0] nidx;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        nidx  = eng_q.idx + 1'b1;
        if (!eng_q.busy) begin
            if (launch) begin
                eng_d.busy    = 1'b1;
                eng_d.started = 1'b0;
                eng_d.is_rd   = launch_rd;
                eng_d.idx     = '0;
                eng_d.frame   = {{PRE_BITS{1'b1}}, 2'b01,
                                 (launch_rd ? 2'b10 : 2'b01),
                                 launch_phy, launch_reg,
                                 (launch_rd ? 2'b11 : 2'b10),
                                 (launch_rd ? {DATA_W{1'b1}} : launch_wdata)};
            end
        end else begin
            if (rise_stb && eng_q.started && eng_q.is_rd &&
                (int'(eng_q.idx) >= RDATA_POS)) begin
                eng_d.shreg = {eng_q.shreg[DATA_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (!eng_q.started) begin
                    eng_d.started = 1'b1;
                    eng_d.idx     = '0;
                    eng_d.mdo     = eng_q.frame[FRAME_BITS-1];
                    eng_d.frame   = eng_q.frame << 1;
                    eng_d.oe      = 1'b1;
                end else if (int'(eng_q.idx) == FRAME_BITS - 1) begin
                    eng_d.busy    = 1'b0;
                    eng_d.started = 1'b0;
                    eng_d.oe      = 1'b0;
                    eng_d.mdo     = 1'b1;
                    done          = 1'b1;
                end else begin
                    eng_d.idx   = nidx;
                    eng_d.mdo   = eng_q.frame[FRAME_BITS-1];
                    eng_d.frame = eng_q.frame << 1;
                    eng_d.oe    = !(eng_q.is_rd && (int'(nidx) >= TA_POS));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q     <= '0;
            eng_q.mdo <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign mdo     = eng_q.mdo;
    assign mdo_oe  = eng_q.oe;
    assign rd_word = eng_q.shreg;

    // R5
    mdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.mdo != $past(eng_q.mdo)) |-> $past(fall_stb));
    // R6
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.busy |-> !eng_q.oe);
    // R6
    read_turn_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.started && eng_q.is_rd && (int'(eng_q.idx) >= TA_POS)) |-> !eng_q.oe);
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_word,
    output logic              launch,
    output logic              launch_rd,
    output logic [PHY_AW-1:0] launch_phy,
    output logic [REG_AW-1:0] launch_reg,
    output logic [DATA_W-1:0] launch_wdata,
    output logic [CMD_W-1:0]  cmd_word
);
    cmd_word_t         cmd_d, cmd_q;
    logic [DATA_W-1:0] wdat_d, wdat_q;
    logic              busy;
    logic              accept;

    always_comb begin
        cmd_d  = cmd_q;
        wdat_d = wdat_q;
        busy   = cmd_q.rd_go | cmd_q.wr_go;
        accept = wr_en && !wr_sel && !busy &&
                 (wr_data[RD_GO_BIT] || wr_data[WR_GO_BIT]);
        if (accept) begin
            cmd_d.rd_go = wr_data[RD_GO_BIT];
            cmd_d.wr_go = wr_data[WR_GO_BIT] & ~wr_data[RD_GO_BIT];
            cmd_d.phy   = wr_data[PHY_LSB +: PHY_AW];
            cmd_d.regn  = wr_data[REG_LSB +: REG_AW];
        end
        if (wr_en && wr_sel) begin
            wdat_d = wr_data[DATA_W-1:0];
        end
        if (eng_done) begin
            if (cmd_q.rd_go) cmd_d.rdata = eng_word;
            cmd_d.rd_go = 1'b0;
            cmd_d.wr_go = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            wdat_q <= '0;
        end else begin
            cmd_q  <= cmd_d;
            wdat_q <= wdat_d;
        end
    end

    assign launch       = accept;
    assign launch_rd    = wr_data[RD_GO_BIT];
    assign launch_phy   = wr_data[PHY_LSB +: PHY_AW];
    assign launch_reg   = wr_data[REG_LSB +: REG_AW];
    assign launch_wdata = wdat_q;
    assign cmd_word     = {{(CMD_W - $bits(cmd_word_t)){1'b0}}, cmd_q};

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && busy) |=> ($stable(cmd_q.phy) && $stable(cmd_q.regn)));
    // R7
    go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q.rd_go | cmd_q.wr_go) |-> $past(eng_done));
    // R10
    one_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_q.rd_go && cmd_q.wr_go));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [CMD_W-1:0] reg_wr_data,
    output logic [CMD_W-1:0] cmd_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic              rise_stb, fall_stb;
    logic              launch, launch_rd, eng_done;
    logic [PHY_AW-1:0] launch_phy;
    logic [REG_AW-1:0] launch_reg;
    logic [DATA_W-1:0] launch_wdata, eng_word;

    mdio_clk_div #(.MDC_DIV(MDC_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_host_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .wr_sel       (reg_wr_sel),
        .wr_data      (reg_wr_data),
        .eng_done     (eng_done),
        .eng_word     (eng_word),
        .launch       (launch),
        .launch_rd    (launch_rd),
        .launch_phy   (launch_phy),
        .launch_reg   (launch_reg),
        .launch_wdata (launch_wdata),
        .cmd_word     (cmd_rdata)
    );

    mdio_frame_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_stb     (rise_stb),
        .fall_stb     (fall_stb),
        .launch       (launch),
        .launch_rd    (launch_rd),
        .launch_phy   (launch_phy),
        .launch_reg   (launch_reg),
        .launch_wdata (launch_wdata),
        .mdio_i       (mdio_i),
        .mdo          (mdio_o),
        .mdo_oe       (mdio_oe),
        .done         (eng_done),
        .rd_word      (eng_word)
    );
endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
module tb_mdio_cmd_ctrl;
    localparam int DIV = 8;
    localparam int H   = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [15:0] phy_val = 16'h0000;

    // reference model state
    int          m_cnt;
    bit          m_mdc, m_busy, m_isrd, m_mdo, m_oe;
    int          m_pos;
    bit [31:0]   m_cmd;
    bit [15:0]   m_wdata;
    bit          qb[$];
    bit          qo[$];

    always #2 clk = ~clk;

    mdio_cmd_ctrl #(.MDC_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .cmd_rdata(cmd_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic push_bits(input bit [31:0] v, input int n, input bit oe);
        for (int i = n - 1; i >= 0; i--) begin
            qb.push_back(v[i]);
            qo.push_back(oe);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mdc = 0; m_busy = 0; m_isrd = 0; m_mdo = 1; m_oe = 0;
            m_pos = -1; m_cmd = '0; m_wdata = '0;
            qb.delete(); qo.delete();
        end else begin
            bit wrap, fall_ev;
            wrap    = (m_cnt == H - 1);
            fall_ev = wrap && m_mdc;
            if (m_busy) begin
                if (fall_ev) begin
                    if (qb.size() > 0) begin
                        m_mdo = qb.pop_front();
                        m_oe  = qo.pop_front();
                        m_pos++;
                    end else begin
                        m_busy = 0; m_oe = 0; m_mdo = 1;
                        if (m_isrd) m_cmd[15:0] = phy_val;
                        m_cmd[27:26] = 2'b00;
                    end
                end
            end else if (reg_wr_en && !reg_wr_sel && (reg_wr_data[27] || reg_wr_data[26])) begin
                m_busy = 1;
                m_isrd = reg_wr_data[26];
                m_pos  = -1;
                m_cmd[27] = reg_wr_data[27] & ~reg_wr_data[26];
                m_cmd[26] = reg_wr_data[26];
                m_cmd[25:16] = reg_wr_data[25:16];
                qb.delete(); qo.delete();
                push_bits(32'hFFFF_FFFF, 32, 1);
                push_bits(32'b01, 2, 1);
                push_bits(m_isrd ? 32'b10 : 32'b01, 2, 1);
                push_bits({22'b0, reg_wr_data[25:16]}, 10, 1);
                if (m_isrd) push_bits(32'h3_FFFF, 18, 0);
                else begin
                    push_bits(32'b10, 2, 1);
                    push_bits({16'b0, m_wdata}, 16, 1);
                end
            end
            if (reg_wr_en && reg_wr_sel) m_wdata = reg_wr_data[15:0];
            if (wrap) begin m_cnt = 0; m_mdc = ~m_mdc; end
            else m_cnt++;
        end
    end

    // per-cycle comparison and PHY answer, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (mdc !== m_mdc) begin
                errors++; $display("FAIL R4 mdc act=%b exp=%b t=%0t", mdc, m_mdc, $time);
            end
            checks++;
            if (mdio_oe !== m_oe) begin
                errors++; $display("FAIL R6 mdio_oe act=%b exp=%b pos=%0d", mdio_oe, m_oe, m_pos);
            end
            if (m_oe) begin
                checks++;
                if (mdio_o !== m_mdo) begin
                    errors++; $display("FAIL R3 R5 mdio_o act=%b exp=%b pos=%0d", mdio_o, m_mdo, m_pos);
                end
            end
            checks++;
            if (cmd_rdata !== m_cmd) begin
                errors++; $display("FAIL R1 R2 R7 R8 cmd_rdata act=%h exp=%h", cmd_rdata, m_cmd);
            end
            mdio_i <= (m_busy && m_isrd && m_pos >= 48 && m_pos <= 63) ? phy_val[63 - m_pos] : 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 0; reg_wr_data = '0;
    endtask

    function automatic logic [31:0] cmd(input bit w, input bit r, input logic [4:0] a, input logic [4:0] g);
        return {4'b0, w, r, a, g, 16'h0000};
    endfunction

    task automatic wait_idle();
        int n = 0;
        while (cmd_rdata[27:26] != 2'b00 && n < 2000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 cmd", cmd_rdata, 32'h0);
        chk("R9 oe", {31'b0, mdio_oe}, 32'h0);
        chk("R9 mdo", {31'b0, mdio_o}, 32'h1);
        chk("R9 mdc", {31'b0, mdc}, 32'h0);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R1 read, R7 result
        phy_val = 16'hA5C3;
        wr(0, cmd(0, 1, 5'd5, 5'd2));
        chk("R1 busy", cmd_rdata, {4'b0, 2'b01, 5'd5, 5'd2, 16'h0});
        wait_idle();
        chk("R7 read result", cmd_rdata, {4'b0, 2'b00, 5'd5, 5'd2, 16'hA5C3});

        // R2 write, R8 ignored command and data write during busy
        wr(1, 32'h0000_3C96);
        wr(0, cmd(1, 0, 5'd31, 5'd0));
        chk("R2 busy", cmd_rdata[27:16], {2'b10, 5'd31, 5'd0});
        repeat (20) @(negedge clk);
        wr(0, cmd(0, 1, 5'd3, 5'd7));
        wr(1, 32'h0000_FFFF);
        chk("R8 ignored cmd", cmd_rdata[27:16], {2'b10, 5'd31, 5'd0});
        wait_idle();
        chk("R2 done", cmd_rdata, {4'b0, 2'b00, 5'd31, 5'd0, 16'hA5C3});

        // R8 command with no start bit
        wr(0, {4'hF, 2'b00, 5'd9, 5'd9, 16'h1234});
        repeat (3) @(negedge clk);
        chk("R8 no-go cmd", cmd_rdata, {4'b0, 2'b00, 5'd31, 5'd0, 16'hA5C3});

        // R10 both bits set -> read
        phy_val = 16'h0001;
        wr(0, {4'b0, 2'b11, 5'd0, 5'd31, 16'h0});
        chk("R10 only read bit", cmd_rdata[27:26], 32'b01);
        wait_idle();
        chk("R10 read result", cmd_rdata, {4'b0, 2'b00, 5'd0, 5'd31, 16'h0001});

        // read patterns
        phy_val = 16'h8000;
        wr(0, cmd(0, 1, 5'd21, 5'd10));
        wait_idle();
        chk("R7 msb", cmd_rdata[15:0], 32'h8000);
        phy_val = 16'hFFFF;
        wr(0, cmd(0, 1, 5'd10, 5'd21));
        wait_idle();
        chk("R7 ones", cmd_rdata[15:0], 32'hFFFF);

        // write of zeros, read result kept (R2)
        wr(1, 32'h0000_0000);
        wr(0, cmd(1, 0, 5'd21, 5'd21));
        wait_idle();
        chk("R2 keep rdata", cmd_rdata, {4'b0, 2'b00, 5'd21, 5'd21, 16'hFFFF});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule